// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank Tracker

This block watches the command pins of a double data rate synchronous DRAM. On every rising clock edge it reads chip select, clock enable, the row strobe, the column strobe, write enable, the two bank select bits and the address bus. It turns these into one named command and reports that command on registered outputs one cycle later. Address bit 10 is read differently for each command. On a read or write it asks for the bank to be closed once the burst is done. On a precharge it widens the close to every bank.

The block also tracks four banks. Each bank has an idle or open flag and a stored row address. Commands that break the bank rules are flagged and are not applied. These are: an activate to a bank that is already open, a read or write to a closed bank, and a refresh while any bank is open. Closing a bank through auto-precharge takes effect at once, and a single-cycle pulse names the bank. A precharge of all banks has its own pulse.

The pins are sampled on every edge, with no handshake. The block cannot push back on the controller, so every output is valid for one cycle only and must be used in that cycle.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: The pin code {row strobe, column strobe, write enable} selects the command. 111 is NOP, 011 is ACT, 101 is READ, 100 is WRITE, 010 is PRE (PREA if A10=1), 001 is REF (OTHER if clock enable is low), and 110 and 000 are OTHER. It appears on `cmd_o` in the cycle after the sampling edge, using these codes: DESEL=0, NOP=1, ACT=2, READ=3, WRITE=4, PRE=5, PREA=6, REF=7, OTHER=8.
- R2: Chip select high decodes as DESEL (0), whatever the other pins are, and the bank state does not change.
- R3: NOP and OTHER leave every bank flag and every stored row unchanged.
- R4: ACT to an idle bank sets that bank's bit in `bank_open_o` and stores A12..A0 as its row. In the following cycle `row_o` shows the row and `bank_o` shows the bank.
- R5: ACT to an open bank raises `err_act_open_o` for one cycle. The bank stays open with its old row.
- R6: READ or WRITE to an open bank outputs the stored row of that bank on `row_o`. It outputs the column on `col_o`, which is {A11, A9..A0} in the 4-bit organisation and A9..A0 in the 8-bit organisation.
- R7: READ or WRITE to an idle bank raises `err_idle_access_o`, gives `row_o`=0, changes no bank and gives no auto-precharge pulse.
- R8: A legal READ or WRITE with A10=1 closes the target bank at once and pulses `apre_o` for one cycle, with `bank_o` naming the bank.
- R9: PRE with A10=0 closes only the selected bank. PRE to an idle bank is legal and raises no error.
- R10: PRE with A10=1 closes all banks, reports PREA and pulses `prea_o` for one cycle.
- R11: REF with clock enable high reports REF and changes no bank. It raises `err_ref_open_o` if any bank was open.
- R12: During reset all banks are idle, the stored rows are cleared and every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, low selects |
| ras_n | input | 1 | Row strobe pin |
| cas_n | input | 1 | Column strobe pin |
| we_n | input | 1 | Write enable pin |
| cke | input | 1 | Clock enable pin |
| ba | input | BANK_W | Bank select bits |
| addr | input | ROW_W | Address bus A(ROW_W-1)..A0 |
| cmd_o | output | 4 | Decoded command code (R1) |
| bank_o | output | BANK_W | Target bank of ACT/READ/WRITE/PRE, else 0 |
| row_o | output | ROW_W | Row of ACT, or stored row for a legal READ/WRITE |
| col_o | output | COL_W | Column of READ/WRITE, else 0 |
| apre_o | output | 1 | Auto-precharge pulse |
| prea_o | output | 1 | Precharge-all pulse |
| err_act_open_o | output | 1 | Activate to an open bank |
| err_idle_access_o | output | 1 | Read or write to an idle bank |
| err_ref_open_o | output | 1 | Refresh with a bank open |
| bank_open_o | output | 2**BANK_W | Per-bank open flags, current state |

## Verification
The bench uses the default parameters: four banks, a 13-bit row and the 4-bit organisation with an 11-bit column. With these defaults A11 lands in the column's top bit, and address bit 10 can be checked separately from the column. Having four banks lets the bench show that a single-bank precharge leaves the other three untouched. It also lets refresh see a mix of open and idle banks. Random pin codes regularly reach the rare OTHER and clock-enable-low refresh encodings.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;
  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_ACT   = 4'd2,
    CMD_READ  = 4'd3,
    CMD_WRITE = 4'd4,
    CMD_PRE   = 4'd5,
    CMD_PREA  = 4'd6,
    CMD_REF   = 4'd7,
    CMD_OTHER = 4'd8
  } cmd_e;
endpackage

// File: rtl/ddr_pin_decode.sv
module ddr_pin_decode
  import ddr_cmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  input  logic a10,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_READ;
        3'b100:  cmd = CMD_WRITE;
        3'b010:  cmd = a10 ? CMD_PREA : CMD_PRE;
        3'b001:  cmd = cke ? CMD_REF : CMD_OTHER;
        default: cmd = CMD_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot #(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_en,
  input  logic             close_en,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      row_q   <= '0;
    end else if (close_en) begin
      is_open <= 1'b0;
      row_q   <= '0;
    end else if (open_en) begin
      is_open <= 1'b1;
      row_q   <= row_in;
    end
  end
endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
  import ddr_cmd_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  parameter bit COL_X4 = 1'b1,
  localparam int NB    = 1 << BANK_W,
  localparam int COL_W = COL_X4 ? 11 : 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              cke,
  input  logic [BANK_W-1:0] ba,
  input  logic [ROW_W-1:0]  addr,
  output logic [3:0]        cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              apre_o,
  output logic              prea_o,
  output logic              err_act_open_o,
  output logic              err_idle_access_o,
  output logic              err_ref_open_o,
  output logic [NB-1:0]     bank_open_o
);
  cmd_e             cmd_d;
  logic [NB-1:0]    open_vec;
  logic [NB-1:0]    open_en;
  logic [NB-1:0]    close_en;
  logic [ROW_W-1:0] row_tab [NB];
  logic [COL_W-1:0] col_sel;

  ddr_pin_decode u_dec (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .cke  (cke),
    .a10  (addr[10]),
    .cmd  (cmd_d)
  );

  generate
    if (COL_X4) begin : g_col_x4
      assign col_sel = {addr[11], addr[9:0]};
    end else begin : g_col_x8
      assign col_sel = addr[9:0];
    end
  endgenerate

  logic tgt_open, any_open, is_acc, act_ok, acc_ok, ap_hit;
  logic err_act, err_idle, err_ref;

  always_comb begin
    tgt_open = open_vec[ba];
    any_open = |open_vec;
    is_acc   = (cmd_d == CMD_READ) || (cmd_d == CMD_WRITE);
    act_ok   = (cmd_d == CMD_ACT) && !tgt_open;
    acc_ok   = is_acc && tgt_open;
    ap_hit   = acc_ok && addr[10];
    err_act  = (cmd_d == CMD_ACT) && tgt_open;
    err_idle = is_acc && !tgt_open;
    err_ref  = (cmd_d == CMD_REF) && any_open;
  end

  generate
    for (genvar i = 0; i < NB; i++) begin : g_bank
      logic hit;
      assign hit         = (ba == BANK_W'(i));
      assign open_en[i]  = act_ok && hit;
      assign close_en[i] = (cmd_d == CMD_PREA) ||
                           (hit && ((cmd_d == CMD_PRE) || ap_hit));
      ddr_bank_slot #(.ROW_W(ROW_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .open_en (open_en[i]),
        .close_en(close_en[i]),
        .row_in  (addr),
        .is_open (open_vec[i]),
        .row_q   (row_tab[i])
      );
    end
  endgenerate

  assign bank_open_o = open_vec;

  logic [BANK_W-1:0] bank_d;
  logic [ROW_W-1:0]  row_d;
  logic [COL_W-1:0]  col_d;

  always_comb begin
    bank_d = '0;
    if (cmd_d == CMD_ACT || is_acc || cmd_d == CMD_PRE) bank_d = ba;
    row_d = '0;
    if (cmd_d == CMD_ACT)  row_d = addr;
    else if (acc_ok)       row_d = row_tab[ba];
    col_d = is_acc ? col_sel : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_o             <= CMD_DESEL;
      bank_o            <= '0;
      row_o             <= '0;
      col_o             <= '0;
      apre_o            <= 1'b0;
      prea_o            <= 1'b0;
      err_act_open_o    <= 1'b0;
      err_idle_access_o <= 1'b0;
      err_ref_open_o    <= 1'b0;
    end else begin
      cmd_o             <= cmd_d;
      bank_o            <= bank_d;
      row_o             <= row_d;
      col_o             <= col_d;
      apre_o            <= ap_hit;
      prea_o            <= (cmd_d == CMD_PREA);
      err_act_open_o    <= err_act;
      err_idle_access_o <= err_idle;
      err_ref_open_o    <= err_ref;
    end
  end
endmodule

// File: rtl/ddr_cmd_tracker_sva.sv
module ddr_cmd_tracker_sva
  import ddr_cmd_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  parameter bit COL_X4 = 1'b1,
  localparam int NB    = 1 << BANK_W,
  localparam int COL_W = COL_X4 ? 11 : 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              cke,
  input logic [BANK_W-1:0] ba,
  input logic [ROW_W-1:0]  addr,
  input logic [3:0]        cmd_o,
  input logic [BANK_W-1:0] bank_o,
  input logic [ROW_W-1:0]  row_o,
  input logic [COL_W-1:0]  col_o,
  input logic              apre_o,
  input logic              prea_o,
  input logic              err_act_open_o,
  input logic              err_idle_access_o,
  input logic              err_ref_open_o,
  input logic [NB-1:0]     bank_open_o
);
  logic [NB-1:0] open_prev;
  always_ff @(posedge clk) begin
    if (!rst_n) open_prev <= '0;
    else        open_prev <= bank_open_o;
  end

  assert_quiet_cmds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_NOP || cmd_o == CMD_OTHER || cmd_o == CMD_DESEL)
      |-> bank_open_o == open_prev);

  assert_act_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_ACT && !err_act_open_o)
      |-> (bank_open_o[bank_o] && !open_prev[bank_o]));

  assert_act_err_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_act_open_o |-> (cmd_o == CMD_ACT && open_prev[bank_o] && bank_open_o == open_prev));

  assert_idle_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_idle_access_o |-> (!open_prev[bank_o] && bank_open_o == open_prev && !apre_o));

  assert_apre_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    apre_o |-> (open_prev[bank_o] && !bank_open_o[bank_o] &&
                (cmd_o == CMD_READ || cmd_o == CMD_WRITE)));

  assert_prea_all_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prea_o |-> (bank_open_o == '0 && cmd_o == CMD_PREA));

  assert_ref_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_ref_open_o |-> (cmd_o == CMD_REF && open_prev != '0 && bank_open_o == open_prev));

  assert_single_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_act_open_o, err_idle_access_o, err_ref_open_o}));
endmodule

bind ddr_cmd_tracker ddr_cmd_tracker_sva #(
  .ROW_W (ROW_W),
  .BANK_W(BANK_W),
  .COL_X4(COL_X4)
) u_sva (.*);

// File: tb/sim_ddr_cmd_tracker.sv
module sim_ddr_cmd_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 13;
  localparam int BANK_W = 2;
  localparam int NB = 4;
  localparam int COL_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [BANK_W-1:0] ba = '0;
  logic [ROW_W-1:0] addr = '0;
  logic [3:0] cmd_o;
  logic [BANK_W-1:0] bank_o;
  logic [ROW_W-1:0] row_o;
  logic [COL_W-1:0] col_o;
  logic apre_o, prea_o, err_act_open_o, err_idle_access_o, err_ref_open_o;
  logic [NB-1:0] bank_open_o;

  ddr_cmd_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .cmd_o(cmd_o),
    .bank_o(bank_o), .row_o(row_o), .col_o(col_o), .apre_o(apre_o),
    .prea_o(prea_o), .err_act_open_o(err_act_open_o),
    .err_idle_access_o(err_idle_access_o), .err_ref_open_o(err_ref_open_o),
    .bank_open_o(bank_open_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [NB-1:0] m_open;
  logic [ROW_W-1:0] m_row [NB];

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic int exp_cmd(input logic c, r, s, w, k, a10);
    if (c) return 0;
    case ({r, s, w})
      3'b111: return 1;
      3'b011: return 2;
      3'b101: return 3;
      3'b100: return 4;
      3'b010: return a10 ? 6 : 5;
      3'b001: return k ? 7 : 8;
      default: return 8;
    endcase
  endfunction

  task automatic model_reset();
    m_open = '0;
    for (int i = 0; i < NB; i++) m_row[i] = '0;
  endtask

  task automatic issue(input logic c, r, s, w, k, input logic [1:0] b, input logic [12:0] a);
    int ec;
    bit tgt, acc, eap, eea, eei, eer;
    int eb, erow, ecol;
    string rq;
    cs_n = c; ras_n = r; cas_n = s; we_n = w; cke = k; ba = b; addr = a;
    @(negedge clk);
    ec   = exp_cmd(c, r, s, w, k, a[10]);
    tgt  = m_open[b];
    acc  = (ec == 3 || ec == 4);
    eap  = acc && tgt && a[10];
    eea  = (ec == 2) && tgt;
    eei  = acc && !tgt;
    eer  = (ec == 7) && (m_open != '0);
    eb   = (ec == 2 || acc || ec == 5) ? int'(b) : 0;
    erow = (ec == 2) ? int'(a) : ((acc && tgt) ? int'(m_row[b]) : 0);
    ecol = acc ? int'({a[11], a[9:0]}) : 0;
    case (ec)
      0: rq = "R2";
      1, 8: rq = "R3";
      2: rq = eea ? "R5" : "R4";
      3, 4: rq = eei ? "R7" : (eap ? "R8" : "R6");
      5: rq = "R9";
      6: rq = "R10";
      default: rq = "R11";
    endcase
    if (ec == 2 && !tgt) begin m_open[b] = 1'b1; m_row[b] = a; end
    if (ec == 5 || eap) begin m_open[b] = 1'b0; m_row[b] = '0; end
    if (ec == 6) model_reset();
    chk("R1", "cmd", int'(cmd_o), ec);
    chk(rq, "bank", int'(bank_o), eb);
    chk(rq, "row", int'(row_o), erow);
    chk(rq, "col", int'(col_o), ecol);
    chk(rq, "flags", int'({apre_o, prea_o, err_act_open_o, err_idle_access_o, err_ref_open_o}),
        int'({eap, (ec == 6), eea, eei, eer}));
    chk(rq, "open", int'(bank_open_o), int'(m_open));
  endtask

  task automatic check_reset();
    chk("R12", "cmd", int'(cmd_o), 0);
    chk("R12", "row", int'(row_o), 0);
    chk("R12", "flags", int'({apre_o, prea_o, err_act_open_o, err_idle_access_o, err_ref_open_o}), 0);
    chk("R12", "open", int'(bank_open_o), 0);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    model_reset();
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    // directed corner cases: pins c r s w k
    issue(0, 0, 1, 1, 1, 2'd0, 13'h1ABC);   // R4 open bank 0
    issue(0, 0, 1, 1, 1, 2'd0, 13'h0123);   // R5 already open
    issue(0, 1, 1, 1, 1, 2'd0, 13'h0000);   // R3 NOP
    issue(0, 1, 0, 1, 1, 2'd0, 13'h0A05);   // R6 read, A11 set, A10 low
    issue(0, 1, 0, 0, 1, 2'd1, 13'h0007);   // R7 write idle bank
    issue(0, 0, 1, 1, 1, 2'd1, 13'h0F0F);   // R4 open bank 1
    issue(0, 0, 1, 0, 1, 2'd2, 13'h0000);   // R9 precharge idle bank
    issue(0, 1, 0, 0, 1, 2'd1, 13'h0403);   // R8 write auto-precharge
    issue(0, 0, 1, 1, 1, 2'd2, 13'h1111);   // R4
    issue(0, 0, 1, 1, 1, 2'd3, 13'h0222);   // R4
    issue(1, 0, 1, 1, 1, 2'd1, 13'h0333);   // R2 deselect with ACT pins
    issue(0, 0, 0, 1, 1, 2'd0, 13'h0000);   // R11 refresh with open banks
    issue(0, 0, 0, 1, 0, 2'd0, 13'h0000);   // R11 cke low -> OTHER
    issue(0, 0, 1, 0, 1, 2'd2, 13'h0000);   // R9 close bank 2 only
    issue(0, 1, 0, 1, 1, 2'd3, 13'h0000);   // R6 row of bank 3 kept
    issue(0, 0, 1, 0, 1, 2'd1, 13'h0400);   // R10 precharge all
    issue(0, 0, 0, 1, 1, 2'd0, 13'h0000);   // R11 legal refresh
    for (int n = 0; n < 1500; n++) begin
      logic [2:0] p;
      p = 3'($urandom);
      issue(($urandom % 10) == 0, p[2], p[1], p[0], ($urandom % 8) != 0,
            2'($urandom), 13'($urandom));
    end
    rst_n = 1'b0;
    cs_n = 1'b1;
    @(negedge clk);
    model_reset();
    check_reset();
    report();
  end
endmodule